// File: doc/BRIEF.md
# Extended 16-bit multiply-add unit

This block is an integer datapath that computes a 16x16 multiply followed by a 32-bit add. Two 32-bit operands, A and B, are each reduced to one 16-bit half. Per-operand controls choose the half and how it is extended to 32 bits. The two extended halves are multiplied. The product may be moved up by 16 bits and is then added to an addend formed from the 32-bit operand C. A mode select shapes that addend.

The result, the carry out of the add, a zero flag and a sign flag are registered. They appear one clock after the operands are presented. A merge option replaces the upper half of the result with the low half of the original B. With it, several of these operations can be chained to build wider multiplies. Flag outputs change only on cycles that request flag generation. A new operation can be issued on every clock.

The addend modes and their `c_mode` codes are:
- full C (0)
- low half of C (1)
- high half of C (2)
- C plus B shifted up (3)
- sign fix-up of C (4)

The block has no state machine. Its only state is the registered result and flags. When reset is asserted, all of that state is cleared.

Top module: `xmad_unit`

## Requirements
- R1: Operand A is reduced to `op_a[31:16]` when `a_hi` is 1 and to `op_a[15:0]` when `a_hi` is 0. The 16-bit value is sign-extended to 32 bits when `a_sgn` is 1 and zero-extended when `a_sgn` is 0.
- R2: Operand B is reduced and extended in the same way, using `b_hi` and `b_sgn`.
- R3: The product is the low 32 bits of the product of the two extended values. When `prod_shl` is 1, the product is shifted left logically by 16 bits before the add.
- R4: `c_mode` selects the addend as follows:
  - 0, 5, 6 and 7: the full `op_c`.
  - 1: `op_c[15:0]` zero-extended.
  - 2: `op_c[31:16]` placed in bits 15:0, with the upper bits cleared.
- R5: `c_mode` 3 gives the addend `op_c + (op_b << 16)`, kept to 32 bits.
- R6: `c_mode` 4 gives the addend `op_c` unchanged when either extended operand is zero. Otherwise the addend is `op_c` minus 0x10000 for each extended operand whose bit 31 is set, kept to 32 bits.
- R7: The sum is the product plus the addend, kept to 32 bits. The carry is bit 32 of that add.
- R8: When `merge` is 1, the result is `{op_b[15:0], sum[15:0]}`. When `merge` is 0, the result is the sum.
- R9: When `flag_en` is 1, the flags are loaded from the new result: `flag_zero` is set when the result is 0, `flag_neg` is result bit 31, and `flag_carry` is the R7 carry. When `flag_en` is 0, all three flags keep their previous values.
- R10: `result` and the flags are registered and show the operation one clock edge after its inputs. While `rst_n` is 0, they are all 0.
- R11: `c_sgn` has no effect on the result or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | Multiplicand source word |
| op_b | input | 32 | Multiplier source word, also used by the shift-add mode and by merge |
| op_c | input | 32 | Addend source word |
| a_hi | input | 1 | Take the upper half of `op_a` |
| b_hi | input | 1 | Take the upper half of `op_b` |
| a_sgn | input | 1 | Sign-extend the A half |
| b_sgn | input | 1 | Sign-extend the B half |
| c_sgn | input | 1 | Addend signedness hint (no effect on any output bit) |
| prod_shl | input | 1 | Shift the product left by 16 |
| merge | input | 1 | Replace the upper result half with `op_b[15:0]` |
| c_mode | input | 3 | Addend mode code |
| flag_en | input | 1 | Load the flags from this operation |
| result | output | 32 | Registered result |
| flag_zero | output | 1 | Result was zero |
| flag_neg | output | 1 | Result bit 31 |
| flag_carry | output | 1 | Carry out of the 32-bit add |

## Verification
Merge and flag generation can act in the same cycle. In that case the flags must follow the merged word, not the raw sum. Several vectors provoke this:
- A sum whose low half is zero, merged with a nonzero B half. The zero flag must stay clear.
- A merge that places a set bit 15 of B into result bit 31. The sign flag must be set.

The sign fix-up mode also meets the zero-operand bypass in the same cycle. This is provoked with one operand zero and the other negative, and the addend must equal C unchanged. Every cycle is judged against a behavioural model in the bench that tracks the flag state itself.

// File: rtl/xmad_pkg.sv
package xmad_pkg;
    typedef enum logic [2:0] {
        CM_FULL  = 3'd0,
        CM_LOW   = 3'd1,
        CM_HIGH  = 3'd2,
        CM_BSHL  = 3'd3,
        CM_FIXUP = 3'd4
    } cmode_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic carry;
    } flags_t;
endpackage

// File: rtl/xmad_half_ext.sv
module xmad_half_ext #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic [DW-1:0] word,
    input  logic          sel_hi,
    input  logic          sgn,
    output logic [DW-1:0] ext,
    output logic          is_zero,
    output logic          is_neg
);
    localparam int PADW = DW - HW;

    logic [HW-1:0] half;
    logic          fill;

    always_comb begin
        half    = sel_hi ? word[DW-1 -: HW] : word[HW-1:0];
        fill    = sgn & half[HW-1];
        ext     = {{PADW{fill}}, half};
        is_zero = (half == '0);
        is_neg  = ext[DW-1];
    end
endmodule

// File: rtl/xmad_addend.sv
module xmad_addend
    import xmad_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic [DW-1:0] c_word,
    input  logic [DW-1:0] b_word,
    input  logic [2:0]    mode,
    input  logic          a_zero,
    input  logic          b_zero,
    input  logic          a_neg,
    input  logic          b_neg,
    output logic [DW-1:0] addend
);
    localparam int PADW = DW - HW;

    logic [1:0]    neg_cnt;
    logic [DW-1:0] fix_step;
    logic [DW-1:0] fixed_c;

    always_comb begin
        neg_cnt  = {1'b0, a_neg} + {1'b0, b_neg};
        fix_step = {{(DW-2){1'b0}}, neg_cnt} << HW;
        fixed_c  = (a_zero | b_zero) ? c_word : (c_word - fix_step);
        unique case (cmode_e'(mode))
            CM_LOW:   addend = {{PADW{1'b0}}, c_word[HW-1:0]};
            CM_HIGH:  addend = {{PADW{1'b0}}, c_word[DW-1 -: HW]};
            CM_BSHL:  addend = c_word + (b_word << HW);
            CM_FIXUP: addend = fixed_c;
            default:  addend = c_word;
        endcase
    end
endmodule

// File: rtl/xmad_unit.sv
module xmad_unit
    import xmad_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [DW-1:0] op_c,
    input  logic          a_hi,
    input  logic          b_hi,
    input  logic          a_sgn,
    input  logic          b_sgn,
    input  logic          c_sgn,
    input  logic          prod_shl,
    input  logic          merge,
    input  logic [2:0]    c_mode,
    input  logic          flag_en,
    output logic [DW-1:0] result,
    output logic          flag_zero,
    output logic          flag_neg,
    output logic          flag_carry
);
    localparam int UPW = DW - HW;

    // Per-operand half selection, one instance each for A and B
    logic [DW-1:0] ext_v  [2];
    logic          zero_v [2];
    logic          neg_v  [2];
    logic [DW-1:0] src_v  [2];
    logic          hi_v   [2];
    logic          sg_v   [2];

    always_comb begin
        src_v[0] = op_a;  hi_v[0] = a_hi;  sg_v[0] = a_sgn;
        src_v[1] = op_b;  hi_v[1] = b_hi;  sg_v[1] = b_sgn;
    end

    for (genvar i = 0; i < 2; i++) begin : g_opnd
        xmad_half_ext #(.DW(DW), .HW(HW)) u_ext (
            .word    (src_v[i]),
            .sel_hi  (hi_v[i]),
            .sgn     (sg_v[i]),
            .ext     (ext_v[i]),
            .is_zero (zero_v[i]),
            .is_neg  (neg_v[i])
        );
    end

    logic [DW-1:0] addend;

    xmad_addend #(.DW(DW), .HW(HW)) u_addend (
        .c_word (op_c),
        .b_word (op_b),
        .mode   (c_mode),
        .a_zero (zero_v[0]),
        .b_zero (zero_v[1]),
        .a_neg  (neg_v[0]),
        .b_neg  (neg_v[1]),
        .addend (addend)
    );

    // Product and add; c_sgn does not change modular bits
    logic [2*DW-1:0] prod_full;
    logic [DW-1:0]   prod_sh;
    logic [DW:0]     sum_w;
    logic [DW-1:0]   res_d;
    logic            c_hint_unused;
    flags_t          flags_q;

    always_comb begin
        prod_full     = {{DW{1'b0}}, ext_v[0]} * {{DW{1'b0}}, ext_v[1]};
        prod_sh       = prod_shl ? (prod_full[DW-1:0] << HW) : prod_full[DW-1:0];
        sum_w         = {1'b0, prod_sh} + {1'b0, addend};
        res_d         = merge ? {op_b[UPW-1:0], sum_w[HW-1:0]} : sum_w[DW-1:0];
        c_hint_unused = c_sgn;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            flags_q <= '0;
        end else begin
            result <= res_d;
            if (flag_en) begin
                flags_q.zero  <= (res_d == '0);
                flags_q.neg   <= res_d[DW-1];
                flags_q.carry <= sum_w[DW];
            end
        end
    end

    assign flag_zero  = flags_q.zero;
    assign flag_neg   = flags_q.neg;
    assign flag_carry = flags_q.carry;

    // Checks beside the datapath
    assert_merge_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        merge |=> result[DW-1 -: UPW] == $past(op_b[UPW-1:0]));

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en |=> $stable({flag_zero, flag_neg, flag_carry}));

    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en |=> flag_zero == (result == '0));

    assert_sign_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en |=> flag_neg == result[DW-1]);

    assert_high_c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_mode == 3'd2 && op_a == '0 && !merge) |=> result == ($past(op_c) >> HW));

    assert_fixup_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_mode == 3'd4 && op_b == '0 && !merge) |=> result == $past(op_c));
endmodule

// File: tb/xmad_unit_tb.sv
module xmad_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam longint M32 = 64'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] op_a, op_b, op_c;
    logic        a_hi, b_hi, a_sgn, b_sgn, c_sgn, prod_shl, merge, flag_en;
    logic [2:0]  c_mode;
    logic [31:0] result;
    logic        flag_zero, flag_neg, flag_carry;

    int checks = 0;
    int errors = 0;
    logic m_z = 1'b0, m_n = 1'b0, m_c = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmad_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .a_hi(a_hi), .b_hi(b_hi), .a_sgn(a_sgn), .b_sgn(b_sgn), .c_sgn(c_sgn),
        .prod_shl(prod_shl), .merge(merge), .c_mode(c_mode), .flag_en(flag_en),
        .result(result), .flag_zero(flag_zero), .flag_neg(flag_neg),
        .flag_carry(flag_carry)
    );

    function automatic longint ext16(logic [31:0] w, bit hi, bit sg);
        longint h = hi ? w[31:16] : w[15:0];
        if (sg && h[15]) h = h - 65536;
        return h;
    endfunction

    task automatic check(string tag, logic [31:0] er, logic ez, logic en, logic ec);
        checks++;
        if (result !== er || flag_zero !== ez || flag_neg !== en || flag_carry !== ec) begin
            errors++;
            $display("FAIL %s: got res=%h z=%b n=%b c=%b expected res=%h z=%b n=%b c=%b",
                     tag, result, flag_zero, flag_neg, flag_carry, er, ez, en, ec);
        end
    endtask

    task automatic run(string tag, logic [31:0] a, logic [31:0] b, logic [31:0] c,
                       bit ahi, bit bhi, bit as, bit bs, bit cs, bit shl, bit mg,
                       logic [2:0] mode, bit fen);
        longint ea, eb, prod, add, sum, bl, cl;
        logic [31:0] er;
        op_a = a; op_b = b; op_c = c; a_hi = ahi; b_hi = bhi; a_sgn = as; b_sgn = bs;
        c_sgn = cs; prod_shl = shl; merge = mg; c_mode = mode; flag_en = fen;
        ea = ext16(a, ahi, as);
        eb = ext16(b, bhi, bs);
        bl = b; cl = c;
        prod = (ea * eb) & M32;
        if (shl) prod = (prod << 16) & M32;
        case (mode)
            3'd1: add = cl & 64'hFFFF;
            3'd2: add = cl >> 16;
            3'd3: add = (cl + (bl << 16)) & M32;
            3'd4: add = (ea == 0 || eb == 0) ? cl
                      : (cl - 65536 * ((ea < 0 ? 1 : 0) + (eb < 0 ? 1 : 0))) & M32;
            default: add = cl;
        endcase
        sum = prod + add;
        er = sum[31:0];
        if (mg) er = {b[15:0], er[15:0]};
        if (fen) begin
            m_z = (er == 0);
            m_n = er[31];
            m_c = sum[32];
        end
        @(posedge clk);
        #1;
        check(tag, er, m_z, m_n, m_c);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        op_a = '0; op_b = '0; op_c = '0; a_hi = 0; b_hi = 0; a_sgn = 0; b_sgn = 0;
        c_sgn = 0; prod_shl = 0; merge = 0; c_mode = '0; flag_en = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset", 32'h0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R1: half selection and extension of A
        run("R1 A low signed",    32'h8001_7FFF, 32'h2, 32'h0, 0,0,1,1,0,0,0,3'd0,1);
        run("R1 A high signed",   32'h8001_7FFF, 32'h2, 32'h0, 1,0,1,1,0,0,0,3'd0,1);
        run("R1 A high unsigned", 32'h8001_7FFF, 32'h2, 32'h0, 1,0,0,0,0,0,0,3'd0,1);
        // R2: same for B
        run("R2 B high signed",   32'h3, 32'hFFFE_0000, 32'h5, 0,1,1,1,0,0,0,3'd0,1);
        run("R2 B low unsigned",  32'h3, 32'h0000_FFFE, 32'h5, 0,0,0,0,0,0,0,3'd0,1);
        // R3: product shift
        run("R3 product shift",   32'h1234, 32'h10, 32'h1, 0,0,0,0,0,1,0,3'd0,1);
        // R4: addend modes
        run("R4 low C",  32'h2, 32'h3, 32'hABCD_1234, 0,0,0,0,0,0,0,3'd1,1);
        run("R4 high C", 32'h2, 32'h3, 32'hABCD_1234, 0,0,0,0,0,0,0,3'd2,1);
        run("R4 high C zero A", 32'h0, 32'h3, 32'h8765_4321, 0,0,0,0,0,0,0,3'd2,1);
        run("R4 spare code", 32'h2, 32'h3, 32'hABCD_1234, 0,0,0,0,0,0,0,3'd6,1);
        // R5: B shift-add mode
        run("R5 B shift", 32'h4, 32'h0005_0006, 32'h1000_0001, 0,0,0,0,0,0,0,3'd3,1);
        // R6: sign fix-up
        run("R6 both neg",  32'hFFFF, 32'hFFFE, 32'h0003_0000, 0,0,1,1,0,0,0,3'd4,1);
        run("R6 one neg",   32'hFFFF, 32'h0002, 32'h0003_0000, 0,0,1,1,0,0,0,3'd4,1);
        run("R6 zero bypass", 32'hFFFF, 32'h0, 32'h0003_0000, 0,0,1,1,0,0,0,3'd4,1);
        run("R6 unsigned no fix", 32'hFFFF, 32'h2, 32'h0003_0000, 0,0,0,0,0,0,0,3'd4,1);
        // R7: carry and truncation
        run("R7 carry", 32'hFFFF, 32'hFFFF, 32'hFFFF_FFFF, 0,0,0,0,0,0,0,3'd0,1);
        run("R7 wrap zero", 32'h1, 32'h1, 32'hFFFF_FFFF, 0,0,0,0,0,0,0,3'd0,1);
        // R8 with flags: merged low half zero, B nonzero
        run("R8 merge flags", 32'h1, 32'h0000_8000, 32'h0000_8000, 0,0,0,0,0,0,1,3'd0,1);
        run("R8 merge plain", 32'h7, 32'h0000_1234, 32'h0000_0011, 0,0,0,0,0,0,1,3'd0,1);
        // R9: flags hold when generation off
        run("R9 hold", 32'h0, 32'h0, 32'h0, 0,0,0,0,0,0,0,3'd0,0);
        run("R9 hold2", 32'h5, 32'h5, 32'h8000_0000, 0,0,0,0,0,0,0,3'd0,0);
        run("R9 load zero", 32'h0, 32'h0, 32'h0, 0,0,0,0,0,0,0,3'd0,1);
        // R11: c_sgn has no effect
        run("R11 csgn off", 32'hFFFF, 32'h3, 32'hFFFF_0000, 0,0,1,1,0,0,0,3'd4,1);
        run("R11 csgn on",  32'hFFFF, 32'h3, 32'hFFFF_0000, 0,0,1,1,1,0,0,3'd4,1);
        // Mixed random vectors, compared every clock (R7 sum path)
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb, rc;
            logic [2:0]  rm;
            logic [7:0]  rf;
            bit          rs;
            ra = $urandom; rb = $urandom; rc = $urandom; rm = 3'($urandom); rf = 8'($urandom);
            rs = rf[2];
            run("R7 random", ra, rb, rc, rf[0], rf[1], rs, rs, rf[3], rf[4], rf[5], rm, rf[6]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule